// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer with Pulse Generation

This block is a 16-bit up-counter behind a byte-wide write port. Two 16-bit data registers, A and B, set its behaviour. A is always the terminal count: the counter runs from 0 to A and then wraps, so one period is A+1 clocks. Every wrap raises a one-cycle match pulse. A 2-bit mode field decides what else happens on each period. Compare mode flips a toggle output. Capture mode latches the running count on a rising edge of an external input. The two pulse modes drive a PWM output from the B threshold, either once or continuously.

Each data register is written as two bytes. A high-byte write only fills a staging byte. The low-byte write then commits the staged high byte and the new low byte together, so the counter never compares against a half-written value. The control register holds an enable, the mode and a self-clearing counter-clear bit. Turning the enable on from off restarts the count at zero.

Top module: `mtimer16`

## Requirements
- R1: After reset, both bytes of A and B read FFh, the control register reads 00h, and tog_out, pwm_out and match_irq are 0.
- R2: Address map: 0 is control, 1 and 2 are the low and high bytes of A, 3 and 4 are the low and high bytes of B. Reads are combinational, return the committed value, and unused addresses (5 to 7) read 00h.
- R3: A write to a high-byte address does not change the readable or effective 16-bit value. A write to the low-byte address commits {staged high byte, written low byte}.
- R4: Control layout: bit 7 is the enable, bits 5:4 are the mode (00 compare, 01 capture, 10 one-shot pulse, 11 repeating pulse), and bit 0 is the clear bit. Bits 6 and 3:0 always read 0, including the clear bit.
- R5: A control write that turns the enable from 0 to 1 sets the counter to 0 and starts it. While the enable is 0, the counter holds, and no match pulse or toggle occurs.
- R6: A control write with bit 0 = 1 sets the counter to 0, even while it is running with the enable staying 1. A write with the enable already 1 and bit 0 = 0 does not restart the count.
- R7: While enabled, when the counter equals A it returns to 0 on the next clock instead of incrementing. match_irq is high for exactly the clock after that edge, so with A = 5 it pulses every 6 clocks.
- R8: In mode 00, tog_out inverts once per A match.
- R9: In modes 10 and 11, pwm_out is high while enabled and the counter is at or above B, and low otherwise. With A = 9 and B = 4 it is high for 6 of every 10 clocks.
- R10: In mode 10, the A match clears the enable, so the control register reads back with bit 7 = 0, and the counter stops at 0 after one period.
- R11: In mode 01, cap_in passes through a two-flop synchronizer. A rising edge then copies the count into a capture register. A rise driven before edge j of a run started at edge 0 captures the value j+1. In mode 01, addresses 3 and 4 read the capture register instead of B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for addr (combinational) |
| cap_in | input | 1 | Asynchronous capture trigger |
| tog_out | output | 1 | Compare-mode toggle output |
| pwm_out | output | 1 | Pulse-mode waveform output |
| match_irq | output | 1 | One-clock pulse per A match |

## Verification
The assertions assume that A is never zero in the pulse modes and that cap_in needs no metastability modelling beyond the two sampling flops. The stimulus meets both conditions. Every low-byte write to A is adjusted in the bench so that the committed value is non-zero, and cap_in changes only between clock edges. Mode changes, clears and re-enables land at random points within a period, so the checks also cover writes that coincide with a match.

// File: rtl/mtimer16_pkg.sv
package mtimer16_pkg;

    localparam int DW          = 8;
    localparam int CW          = 2 * DW;
    localparam int AW          = 3;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_DREGS   = 2;

    localparam int ADR_CTRL    = 0;
    localparam int ADR_DBASE   = 1;
    localparam int ADR_A_LO    = ADR_DBASE;
    localparam int ADR_A_HI    = ADR_DBASE + 1;
    localparam int ADR_B_LO    = ADR_DBASE + 2;
    localparam int ADR_B_HI    = ADR_DBASE + 3;

    localparam int BIT_EN      = 7;
    localparam int BIT_MS_HI   = 5;
    localparam int BIT_MS_LO   = 4;
    localparam int BIT_CLR     = 0;

    typedef enum logic [1:0] {
        MD_CMP  = 2'b00,
        MD_CAPT = 2'b01,
        MD_ONCE = 2'b10,
        MD_LOOP = 2'b11
    } mode_e;

    typedef struct packed {
        logic  en;
        mode_e mode;
    } ctl_t;

    function automatic logic is_ppg(mode_e m);
        return m[1];
    endfunction

    function automatic logic [DW-1:0] ctl_byte(ctl_t c);
        logic [DW-1:0] r;
        r = '0;
        r[BIT_EN] = c.en;
        r[BIT_MS_HI:BIT_MS_LO] = c.mode;
        return r;
    endfunction

endpackage

// File: rtl/mtimer16_regs.sv
module mtimer16_regs
    import mtimer16_pkg::*;
#(
    parameter int P_DW = DW,
    parameter int P_AW = AW,
    parameter int P_NR = NUM_DREGS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [P_AW-1:0]               addr,
    input  logic [P_DW-1:0]               wdata,
    output logic [P_NR-1:0][2*P_DW-1:0]   vals
);
    localparam int VW = 2 * P_DW;

    for (genvar g = 0; g < P_NR; g++) begin : g_dreg
        localparam logic [P_AW-1:0] LO_ADR = P_AW'(ADR_DBASE + 2 * g);
        localparam logic [P_AW-1:0] HI_ADR = P_AW'(ADR_DBASE + 2 * g + 1);

        logic [VW-1:0]   val_q;
        logic [P_DW-1:0] stg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '1;
                stg_q <= '1;
            end else if (wr_en) begin
                if (addr == HI_ADR) stg_q <= wdata;
                if (addr == LO_ADR) val_q <= {stg_q, wdata};
            end
        end

        assign vals[g] = val_q;
    end

endmodule

// File: rtl/mtimer16_core.sv
module mtimer16_core
    import mtimer16_pkg::*;
#(
    parameter int P_CW = CW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctrl_wr,
    input  logic            wr_en_bit,
    input  logic [1:0]      wr_mode,
    input  logic            wr_clr,
    input  logic [P_CW-1:0] a_val,
    input  logic [P_CW-1:0] b_val,
    output ctl_t            ctl,
    output logic [P_CW-1:0] cnt,
    output logic            tog_out,
    output logic            match_irq,
    output logic            pwm_out
);
    ctl_t            ctl_q, ctl_d;
    logic [P_CW-1:0] cnt_q, cnt_d;
    logic            tog_q, irq_q;
    logic            start, stop, hit;

    always_comb begin
        start = ctrl_wr && ((wr_en_bit && !ctl_q.en) || wr_clr);
        stop  = ctrl_wr && !wr_en_bit;
        hit   = ctl_q.en && !start && !stop && (cnt_q == a_val);

        if (start || hit)           cnt_d = '0;
        else if (ctl_q.en && !stop) cnt_d = cnt_q + 1'b1;
        else                        cnt_d = cnt_q;

        ctl_d = ctl_q;
        if (ctrl_wr) begin
            ctl_d.en   = wr_en_bit;
            ctl_d.mode = mode_e'(wr_mode);
        end
        if (hit && ctl_q.mode == MD_ONCE) ctl_d.en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{en: 1'b0, mode: MD_CMP};
            cnt_q <= '0;
            tog_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            cnt_q <= cnt_d;
            irq_q <= hit;
            if (hit && ctl_q.mode == MD_CMP) tog_q <= ~tog_q;
        end
    end

    assign ctl       = ctl_q;
    assign cnt       = cnt_q;
    assign tog_out   = tog_q;
    assign match_irq = irq_q;
    assign pwm_out   = ctl_q.en && is_ppg(ctl_q.mode) && (cnt_q >= b_val);

endmodule

// File: rtl/mtimer16_capt.sv
module mtimer16_capt
    import mtimer16_pkg::*;
#(
    parameter int P_CW     = CW,
    parameter int P_STAGES = SYNC_STAGES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_in,
    input  logic            arm,
    input  logic [P_CW-1:0] cnt,
    output logic [P_CW-1:0] cap_val
);
    logic [P_STAGES:0] sh_q;
    logic              rise;

    assign rise = sh_q[P_STAGES-1] && !sh_q[P_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            cap_val <= '0;
        end else begin
            sh_q <= {sh_q[P_STAGES-1:0], cap_in};
            if (rise && arm) cap_val <= cnt;
        end
    end

endmodule

// File: rtl/mtimer16.sv
module mtimer16
    import mtimer16_pkg::*;
#(
    parameter int P_DW = DW,
    parameter int P_AW = AW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [P_AW-1:0] addr,
    input  logic [P_DW-1:0] wdata,
    output logic [P_DW-1:0] rdata,
    input  logic            cap_in,
    output logic            tog_out,
    output logic            pwm_out,
    output logic            match_irq
);
    localparam int VW = 2 * P_DW;

    logic [NUM_DREGS-1:0][VW-1:0] vals;
    logic [VW-1:0] a_val, b_val, cnt, cap_val, bsel;
    ctl_t          ctl;
    logic          ctrl_wr;

    assign ctrl_wr = wr_en && (addr == P_AW'(ADR_CTRL));
    assign a_val   = vals[0];
    assign b_val   = vals[1];

    mtimer16_regs #(.P_DW(P_DW), .P_AW(P_AW), .P_NR(NUM_DREGS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .vals  (vals)
    );

    mtimer16_core #(.P_CW(VW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .wr_en_bit (wdata[BIT_EN]),
        .wr_mode   (wdata[BIT_MS_HI:BIT_MS_LO]),
        .wr_clr    (wdata[BIT_CLR]),
        .a_val     (a_val),
        .b_val     (b_val),
        .ctl       (ctl),
        .cnt       (cnt),
        .tog_out   (tog_out),
        .match_irq (match_irq),
        .pwm_out   (pwm_out)
    );

    mtimer16_capt #(.P_CW(VW), .P_STAGES(SYNC_STAGES)) u_capt (
        .clk     (clk),
        .rst     (rst),
        .cap_in  (cap_in),
        .arm     (ctl.en && ctl.mode == MD_CAPT),
        .cnt     (cnt),
        .cap_val (cap_val)
    );

    assign bsel = (ctl.mode == MD_CAPT) ? cap_val : b_val;

    always_comb begin
        case (int'(addr))
            ADR_CTRL: rdata = ctl_byte(ctl);
            ADR_A_LO: rdata = a_val[P_DW-1:0];
            ADR_A_HI: rdata = a_val[VW-1:P_DW];
            ADR_B_LO: rdata = bsel[P_DW-1:0];
            ADR_B_HI: rdata = bsel[VW-1:P_DW];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/mtimer16_chk.sv
module mtimer16_chk
    import mtimer16_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          ctrl_wr,
    input ctl_t          ctl,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] a_val,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] rdata,
    input logic          tog_out,
    input logic          pwm_out,
    input logic          match_irq
);
    // R7: a match with no control write wraps the count to zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && !ctrl_wr && cnt == a_val) |=> (cnt == '0));

    // R7: the match pulse follows a cycle where the count sat at A
    a_r7_irq_src: assert property (@(posedge clk) disable iff (rst)
        match_irq |-> ($past(cnt) == $past(a_val) && $past(ctl.en)));

    // R5: a stopped counter holds without control writes
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !ctrl_wr) |=> $stable(cnt));

    // R8: the toggle only moves with a compare-mode match
    a_r8_tog: assert property (@(posedge clk) disable iff (rst)
        !$stable(tog_out) |-> (match_irq && $past(ctl.mode) == MD_CMP));

    // R9: no waveform while disabled
    a_r9_pwm_off: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |-> !pwm_out);

    // R10: a one-shot match leaves the timer disabled
    a_r10_once: assert property (@(posedge clk) disable iff (rst)
        (match_irq && $past(ctl.mode) == MD_ONCE) |-> !ctl.en);

    // R4: reserved control bits read zero
    a_r4_rsvd: assert property (@(posedge clk) disable iff (rst)
        (addr == AW'(ADR_CTRL)) |-> (rdata[6] == 1'b0 && rdata[3:0] == 4'h0));

endmodule

bind mtimer16 mtimer16_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctl       (ctl),
    .cnt       (cnt),
    .a_val     (a_val),
    .addr      (addr),
    .rdata     (rdata),
    .tog_out   (tog_out),
    .pwm_out   (pwm_out),
    .match_irq (match_irq)
);

// File: tb/mtimer16_bench.sv
`timescale 1ns/1ps
module mtimer16_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic       cap_in = 1'b0;
    logic [7:0] rdata;
    logic       tog_out, pwm_out, match_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mtimer16 u_mtimer16 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .tog_out(tog_out),
        .pwm_out(pwm_out), .match_irq(match_irq)
    );

    // reference state built from the requirements
    bit        m_en, m_tog, m_irq;
    bit [1:0]  m_mode;
    bit [15:0] m_cnt, m_a, m_b, m_cap;
    bit [7:0]  m_sa, m_sb;
    bit [2:0]  m_sh;
    bit        cw, st, sp, hh, rz, n_en;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_tog = 0; m_irq = 0; m_mode = 0; m_cnt = 0;
            m_a = 16'hFFFF; m_b = 16'hFFFF; m_sa = 8'hFF; m_sb = 8'hFF;
            m_cap = 0; m_sh = 0;
        end else begin
            cw = wr_en && addr == 3'd0;
            st = cw && ((wdata[7] && !m_en) || wdata[0]);
            sp = cw && !wdata[7];
            hh = m_en && !st && !sp && (m_cnt == m_a);
            rz = m_sh[1] && !m_sh[2];
            if (rz && m_en && m_mode == 2'b01) m_cap = m_cnt;
            m_irq = hh;
            if (hh && m_mode == 2'b00) m_tog = !m_tog;
            n_en = cw ? wdata[7] : m_en;
            if (hh && m_mode == 2'b10) n_en = 0;
            if (st || hh) m_cnt = 0;
            else if (m_en && !sp) m_cnt = m_cnt + 16'd1;
            m_en = n_en;
            if (cw) m_mode = wdata[5:4];
            if (wr_en) begin
                case (addr)
                    3'd1: m_a = {m_sa, wdata};
                    3'd2: m_sa = wdata;
                    3'd3: m_b = {m_sb, wdata};
                    3'd4: m_sb = wdata;
                    default: ;
                endcase
            end
            m_sh = {m_sh[1:0], cap_in};
        end
    end

    function automatic bit [7:0] exp_rd(bit [2:0] ad);
        bit [15:0] bs;
        bs = (m_mode == 2'b01) ? m_cap : m_b;
        case (ad)
            3'd0: return {m_en, 1'b0, m_mode, 4'h0};
            3'd1: return m_a[7:0];
            3'd2: return m_a[15:8];
            3'd3: return bs[7:0];
            3'd4: return bs[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit exp_pwm();
        return m_en && m_mode[1] && (m_cnt >= m_b);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        string rt;
        rt = (addr == 3'd0) ? "R4 ctrl read" :
             ((addr == 3'd3 || addr == 3'd4) && m_mode == 2'b01) ? "R11 capture read" :
             "R2 register read";
        chk(rt, {8'h0, rdata}, {8'h0, exp_rd(addr)});
        chk("R7 match_irq", {15'h0, match_irq}, {15'h0, m_irq});
        chk("R8 tog_out", {15'h0, tog_out}, {15'h0, m_tog});
        chk("R9 pwm_out", {15'h0, pwm_out}, {15'h0, exp_pwm()});
    endtask

    // drive at negedge, take one edge, compare at the following negedge
    task automatic tick(bit w, bit [2:0] ad, bit [7:0] d);
        wr_en = w; addr = ad; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0;
        cmp_model();
    endtask

    int c_irq, c_pwm, c_tog;
    task automatic run(int n);
        bit pt;
        c_irq = 0; c_pwm = 0; c_tog = 0;
        for (int i = 0; i < n; i++) begin
            pt = tog_out;
            tick(0, 3'd0, 8'h00);
            if (match_irq) c_irq++;
            if (pwm_out) c_pwm++;
            if (tog_out != pt) c_tog++;
        end
    endtask

    task automatic rd(bit [2:0] ad, bit [7:0] exp, string tag);
        tick(0, ad, 8'h00);
        chk(tag, {8'h0, rdata}, {8'h0, exp});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all R): actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit [7:0] v;
        int r;
        r = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst = 0;
        // R1: reset values
        chk("R1 tog", {15'h0, tog_out}, 16'h0);
        chk("R1 pwm", {15'h0, pwm_out}, 16'h0);
        chk("R1 irq", {15'h0, match_irq}, 16'h0);
        rd(3'd0, 8'h00, "R1 ctrl");
        rd(3'd1, 8'hFF, "R1 A lo");
        rd(3'd2, 8'hFF, "R1 A hi");
        rd(3'd3, 8'hFF, "R1 B lo");
        rd(3'd4, 8'hFF, "R1 B hi");
        rd(3'd6, 8'h00, "R2 unused addr");
        // R3: staging
        tick(1, 3'd2, 8'h00);
        rd(3'd2, 8'hFF, "R3 hi held until low write");
        tick(1, 3'd1, 8'h05);
        rd(3'd2, 8'h00, "R3 hi committed");
        rd(3'd1, 8'h05, "R3 lo committed");
        // R7/R8: compare mode, A=5
        tick(1, 3'd0, 8'h80);
        run(60);
        chk("R7 irq count A=5", 16'(c_irq), 16'd10);
        chk("R8 toggle count", 16'(c_tog), 16'd10);
        // R5: disabled holds
        tick(1, 3'd0, 8'h00);
        run(20);
        chk("R5 no irq while off", 16'(c_irq), 16'd0);
        chk("R5 no toggle while off", 16'(c_tog), 16'd0);
        // R10: one-shot A=9 B=4
        tick(1, 3'd4, 8'h00);
        tick(1, 3'd3, 8'h04);
        tick(1, 3'd1, 8'h09);
        tick(1, 3'd0, 8'hA0);
        run(25);
        chk("R10 one-shot pwm cycles", 16'(c_pwm), 16'd6);
        chk("R10 one-shot single match", 16'(c_irq), 16'd1);
        rd(3'd0, 8'h20, "R10 enable cleared");
        // R9: repeating pulse
        tick(1, 3'd0, 8'hB0);
        run(40);
        chk("R9 repeat pwm cycles", 16'(c_pwm), 16'd24);
        chk("R9 repeat matches", 16'(c_irq), 16'd4);
        // R11: capture
        tick(1, 3'd2, 8'hFF);
        tick(1, 3'd1, 8'hFF);
        tick(1, 3'd0, 8'h10);
        tick(1, 3'd0, 8'h90);
        run(10);
        cap_in = 1;
        run(5);
        rd(3'd3, 8'h0C, "R11 capture lo");
        rd(3'd4, 8'h00, "R11 capture hi");
        cap_in = 0;
        // R6: clear while running
        tick(1, 3'd0, 8'h91);
        run(4);
        cap_in = 1;
        run(5);
        rd(3'd3, 8'h06, "R6 clear restarted count");
        rd(3'd0, 8'h90, "R6 clear bit reads zero");
        cap_in = 0;
        // random phase
        for (int i = 0; i < 4000; i++) begin
            r = int'($urandom % 16);
            case (r)
                0, 1: tick(1, 3'd0, 8'($urandom) & 8'hF1 | ((($urandom % 4) == 0) ? 8'h01 : 8'h00) & 8'hFF);
                2, 3: begin
                    v = 8'($urandom % 32);
                    if ({m_sa, v} == 16'h0) v = 8'h01;
                    tick(1, 3'd1, v);
                end
                4: tick(1, 3'd2, (($urandom % 4) == 0) ? 8'($urandom) : 8'h00);
                5, 6: tick(1, 3'd3, 8'($urandom % 40));
                7: tick(1, 3'd4, (($urandom % 4) == 0) ? 8'($urandom) : 8'h00);
                8, 9: begin
                    cap_in = ~cap_in;
                    tick(0, 3'($urandom), 8'h00);
                end
                default: tick(0, 3'($urandom), 8'h00);
            endcase
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule